// File: doc/BRIEF.md
# Roll and Scan Acquisition Write Controller

This block steers the writes of a waveform record memory that holds one screen of samples. For every valid sample it produces a write strobe and a write address. It also produces a display-progress pointer that tells a display engine how much of the record may be drawn. Two acquisition styles are supported. The roll style is accepted only when the timebase is slow.

In roll, every sample is written into a ring that spans the whole record. The controller reports where the oldest stored sample sits, and trigger, gate and holdoff have no influence.

In scan, a gate pulse opens an acquisition cycle with a programmable count of pretrigger samples. Those samples circulate in a small ring at the bottom of the record. Once that ring has been filled at least once, an accepted trigger releases the whole pretrigger block to the display in one step. A one-cycle commit strobe and the ring's oldest position mark that step. The samples after the trigger are then written one by one up to the last record location. The display pointer follows them. At the end a completion flag rises, and writing stops until the next gate.

Top module: `scanroll_wctl`

## Requirements
- R1: After reset, wr_en, pre_commit, rec_done and roll_on are 0, and disp_ptr is 0.
- R2: roll_on equals roll_req AND NOT fast_tb. When fast_tb is 1, a roll request is refused and the scan behaviour applies.
- R3: In roll, each cycle with smp_vld high writes (wr_en=1) at an address that steps 0,1,…,DEPTH-1 and wraps to 0. The address restarts at 0 one cycle after roll becomes active, and disp_ptr counts the stored samples, saturating at DEPTH.
- R4: In roll, origin is 0 until the ring has wrapped once. After that it equals the location the next sample will overwrite, which is the oldest one.
- R5: In roll, trig, gate and holdoff have no effect: pre_commit stays 0 and the address sequence continues unchanged.
- R6: In scan, a gate pulse starts a cycle only from the idle or completed state. It captures pre_len (P), clears disp_ptr and rec_done, and a gate during an acquisition is ignored.
- R7: During the pretrigger phase, samples are written at addresses 0,1,…,P-1, repeating circularly.
- R8: A trigger with holdoff low that arrives before P pretrigger samples have been written is remembered and accepted in the first cycle after the ring has filled. A trigger with holdoff high is ignored.
- R9: One cycle after a trigger is accepted, pre_commit is 1 for exactly one cycle, disp_ptr equals P, and origin holds the oldest ring location. A sample in the accepting cycle still goes into the ring.
- R10: After acceptance, samples are written at addresses P, P+1, …, DEPTH-1, and after the write at address a, disp_ptr becomes a+1.
- R11: One cycle after the write at DEPTH-1, rec_done is 1 and disp_ptr equals DEPTH. wr_en then stays 0 for any smp_vld until the next gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample is available this cycle |
| trig | input | 1 | Trigger event |
| roll_req | input | 1 | Request roll acquisition (0 = scan) |
| fast_tb | input | 1 | Timebase is too fast for roll |
| gate | input | 1 | Start of a scan acquisition cycle |
| holdoff | input | 1 | Trigger acceptance blocked while high |
| pre_len | input | $clog2(DEPTH) | Count of pretrigger samples P |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | $clog2(DEPTH) | Memory write address |
| disp_ptr | output | $clog2(DEPTH)+1 | Extent of the record valid for display |
| origin | output | $clog2(DEPTH) | Oldest sample location (roll ring or pretrigger ring) |
| pre_commit | output | 1 | One-cycle strobe: pretrigger block released |
| rec_done | output | 1 | Scan record complete |
| roll_on | output | 1 | Roll acquisition active |

## Verification
The bench builds the controller with DEPTH=16, so that both the full-record ring in roll and the end of a scan record come within a few dozen samples. It runs scan cycles with pre_len values of 5 and 3. The value 5 lets a trigger arrive before the ring is full and be held pending. The value 3 makes the pretrigger ring wrap twice, so the committed origin is not zero. Roll is exercised past one full wrap, which brings the saturation of disp_ptr and the move of origin away from 0 into reach.

// File: rtl/scanroll_wctl.sv
module scanroll_wctl #(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic                       trig,
  input  logic                       roll_req,
  input  logic                       fast_tb,
  input  logic                       gate,
  input  logic                       holdoff,
  input  logic [$clog2(DEPTH)-1:0]   pre_len,
  output logic                       wr_en,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [$clog2(DEPTH):0]     disp_ptr,
  output logic [$clog2(DEPTH)-1:0]   origin,
  output logic                       pre_commit,
  output logic                       rec_done,
  output logic                       roll_on
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_POST, S_DONE} st_t;
  st_t st;

  logic          roll_q, pfull, pend, rfull, commit_r, done_r;
  logic [AW-1:0] plen, pwp, pst, rwp, org;
  logic [AW:0]   dptr;

  assign roll_on = roll_req & ~fast_tb;

  logic          mode_chg, trig_ok, ring_wr, accept;
  logic [AW-1:0] plen_in, pwp_nx;

  assign mode_chg = roll_on ^ roll_q;
  assign trig_ok  = trig & ~holdoff;
  assign plen_in  = (pre_len > LAST) ? LAST : pre_len;
  assign ring_wr  = smp_vld && (plen != '0);
  assign pwp_nx   = (pwp == plen - 1'b1) ? '0 : pwp + 1'b1;
  assign accept   = !roll_on && !mode_chg && st == S_PRE && pfull && (trig_ok || pend);

  assign wr_en    = smp_vld && !mode_chg &&
                    (roll_on || (st == S_PRE && plen != '0) || st == S_POST);
  assign wr_addr  = roll_on ? rwp : (st == S_POST ? pst : pwp);
  assign origin   = roll_on ? (rfull ? rwp : '0) : org;
  assign disp_ptr = dptr;
  assign pre_commit = commit_r;
  assign rec_done   = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      roll_q <= 1'b0;
      pfull <= 1'b0;
      pend <= 1'b0;
      rfull <= 1'b0;
      commit_r <= 1'b0;
      done_r <= 1'b0;
      plen <= '0;
      pwp <= '0;
      pst <= '0;
      rwp <= '0;
      org <= '0;
      dptr <= '0;
    end else begin
      roll_q   <= roll_on;
      commit_r <= 1'b0;
      if (mode_chg) begin
        st <= S_IDLE;
        rwp <= '0;
        rfull <= 1'b0;
        dptr <= '0;
        org <= '0;
        pend <= 1'b0;
        done_r <= 1'b0;
      end else if (roll_on) begin
        if (smp_vld) begin
          rwp <= (rwp == LAST) ? '0 : rwp + 1'b1;
          if (rwp == LAST) rfull <= 1'b1;
          if (dptr != FULL) dptr <= dptr + 1'b1;
        end
      end else begin
        case (st)
          S_IDLE, S_DONE: if (gate) begin
            st <= S_PRE;
            plen <= plen_in;
            pwp <= '0;
            pfull <= (plen_in == '0);
            pend <= 1'b0;
            dptr <= '0;
            done_r <= 1'b0;
            org <= '0;
          end
          S_PRE: begin
            if (ring_wr) begin
              pwp <= pwp_nx;
              if (pwp == plen - 1'b1) pfull <= 1'b1;
            end
            if (accept) begin
              st <= S_POST;
              commit_r <= 1'b1;
              dptr <= {1'b0, plen};
              pst <= plen;
              pend <= 1'b0;
              org <= ring_wr ? pwp_nx : pwp;
            end else if (trig_ok) begin
              pend <= 1'b1;
            end
          end
          S_POST: if (smp_vld) begin
            dptr <= {1'b0, pst} + 1'b1;
            if (pst == LAST) begin
              st <= S_DONE;
              done_r <= 1'b1;
            end else begin
              pst <= pst + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_commit |=> !pre_commit);
  // R11
  no_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && !roll_on) |-> !wr_en);
  // R5
  roll_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_on && roll_q) |=> !pre_commit);
  // R3
  dptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ptr <= FULL);
  // R7
  pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll_on && st == S_PRE && wr_en) |-> wr_addr < plen);
  // R10
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll_on && st == S_POST && wr_en) |-> wr_addr >= plen);
endmodule

// File: tb/tb_scanroll_wctl.sv
module tb_scanroll_wctl;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic smp_vld = 0, trig = 0, roll_req = 0, fast_tb = 0, gate = 0, holdoff = 0;
  logic [AW-1:0] pre_len = '0;
  logic wr_en, pre_commit, rec_done, roll_on;
  logic [AW-1:0] wr_addr, origin;
  logic [AW:0] disp_ptr;

  scanroll_wctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .trig(trig), .roll_req(roll_req),
    .fast_tb(fast_tb), .gate(gate), .holdoff(holdoff), .pre_len(pre_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .disp_ptr(disp_ptr), .origin(origin),
    .pre_commit(pre_commit), .rec_done(rec_done), .roll_on(roll_on));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit in_roll = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv(input bit v, input bit t, input bit g, input bit h, input bit ew, input int ea);
    @(posedge clk); #2;
    smp_vld = v; trig = t; gate = g; holdoff = h;
    if (ew) exp_q.push_back(ea);
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (exp_q.size() == 0) chk(0, "R3/R7/R10/R11", "unexpected write addr", int'(wr_addr), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(wr_addr) == e, "R3/R7/R10", "wr_addr", int'(wr_addr), e);
      end
    end
    if (in_roll && pre_commit) chk(0, "R5", "pre_commit in roll", 1, 0);
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      chk(0, "watchdog", "timeout", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1
    chk(wr_en == 0 && pre_commit == 0 && rec_done == 0 && roll_on == 0, "R1", "reset flags", 0, 0);
    chk(disp_ptr == 0, "R1", "reset disp_ptr", int'(disp_ptr), 0);

    // Scan, P=5, early trigger held pending (R6 R7 R8 R9)
    pre_len = 5;
    drv(0, 0, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 1, 0);
    drv(1, 1, 0, 0, 1, 1);
    drv(1, 0, 0, 0, 1, 2);
    @(negedge clk);
    chk(pre_commit == 0, "R8", "no commit before ring full", int'(pre_commit), 0);
    drv(1, 0, 0, 0, 1, 3);
    drv(1, 0, 0, 0, 1, 4);
    idle();
    idle();
    @(negedge clk);
    chk(pre_commit == 1, "R9", "commit after pending trigger", int'(pre_commit), 1);
    chk(disp_ptr == 5, "R9", "disp_ptr at commit", int'(disp_ptr), 5);
    chk(origin == 0, "R9", "origin at commit", int'(origin), 0);
    idle();
    @(negedge clk);
    chk(pre_commit == 0, "R9", "commit single cycle", int'(pre_commit), 0);
    drv(1, 0, 0, 0, 1, 5);
    idle();
    @(negedge clk);
    chk(disp_ptr == 6, "R10", "disp_ptr after first post", int'(disp_ptr), 6);
    for (int a = 6; a < DEPTH; a++) drv(1, 0, 0, 0, 1, a);
    idle();
    @(negedge clk);
    chk(rec_done == 1, "R11", "rec_done", int'(rec_done), 1);
    chk(disp_ptr == DEPTH, "R11", "disp_ptr full", int'(disp_ptr), DEPTH);
    drv(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(wr_en == 0, "R11", "no write after done", int'(wr_en), 0);

    // Scan, P=3, ring wraps, holdoff blocks trigger, gate ignored mid-cycle
    pre_len = 3;
    drv(0, 0, 1, 0, 0, 0);
    idle();
    @(negedge clk);
    chk(rec_done == 0 && disp_ptr == 0, "R6", "gate clears record", int'(disp_ptr), 0);
    for (int i = 0; i < 7; i++) drv(1, (i == 4), 0, (i == 4), 1, i % 3);
    idle();
    @(negedge clk);
    chk(pre_commit == 0, "R8", "holdoff trigger ignored", int'(pre_commit), 0);
    drv(1, 1, 0, 0, 1, 1);
    idle();
    @(negedge clk);
    chk(pre_commit == 1 && disp_ptr == 3, "R9", "commit P=3 disp_ptr", int'(disp_ptr), 3);
    chk(origin == 2, "R9", "origin after wrapped ring", int'(origin), 2);
    drv(1, 0, 1, 0, 1, 3);
    for (int a = 4; a < DEPTH; a++) drv(1, 0, 0, 0, 1, a);
    idle();
    @(negedge clk);
    chk(rec_done == 1 && disp_ptr == DEPTH, "R6", "gate mid-cycle ignored, record completes", int'(disp_ptr), DEPTH);

    // Roll refused on fast timebase (R2)
    @(posedge clk); #2 roll_req = 1; fast_tb = 1; smp_vld = 1;
    @(negedge clk);
    chk(roll_on == 0, "R2", "roll refused", int'(roll_on), 0);
    chk(wr_en == 0, "R2", "scan behaviour kept", int'(wr_en), 0);
    @(posedge clk); #2 fast_tb = 0; smp_vld = 0;
    @(negedge clk);
    chk(roll_on == 1, "R2", "roll accepted", int'(roll_on), 1);
    in_roll = 1;
    for (int i = 0; i < 10; i++) drv(1, 1, (i == 3), (i == 5), 1, i);
    idle();
    @(negedge clk);
    chk(disp_ptr == 10, "R3", "roll count", int'(disp_ptr), 10);
    chk(origin == 0, "R4", "origin before wrap", int'(origin), 0);
    for (int i = 10; i < 20; i++) drv(1, (i % 2), 0, 0, 1, i % DEPTH);
    idle();
    @(negedge clk);
    chk(disp_ptr == DEPTH, "R3", "roll count saturates", int'(disp_ptr), DEPTH);
    chk(origin == 4, "R4", "origin oldest after wrap", int'(origin), 4);
    chk(pre_commit == 0 && rec_done == 0, "R5", "trigger no effect in roll", int'(pre_commit), 0);

    @(posedge clk); #2 roll_req = 0; in_roll = 0;
    idle();
    @(negedge clk);
    chk(roll_on == 0 && disp_ptr == 0, "R6", "back to scan idle", int'(disp_ptr), 0);
    chk(exp_q.size() == 0, "R3/R7/R10", "missing writes", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule